// File: doc/BRIEF.md
# Cursor Image Checksum Engine

This block computes a 32-bit checksum over a cursor bitmap stored in a buffer of 16-bit pixels. The buffer has a fixed pitch set by the largest cursor width. A start pulse latches the active width and height. The engine then walks the active pixels row by row through a synchronous word-wide read port. In each row it adds every pair of pixels as one 32-bit word. When the width is odd, it also adds the last pixel of the row as a zero-extended halfword. The unused words at the end of each row are never fetched.

A 32-byte signature block sits directly after the image area. Its first word holds the checksum that was stored with the image. After the image sum is complete, the engine reads that word and compares it with its own result. It then reports the sum, a match flag and a one-cycle done pulse. If a width or height is out of range, the engine reports an error and does no memory traffic.

Top module: `cursor_cksum`

## Requirements
- R1: Each 32-bit word fetched for a pair of pixels is added in full to the accumulator. The left pixel of the pair is in bits 15:0 and the right pixel is in bits 31:16.
- R2: When the width is odd, the last word of each row is masked and only its bits 15:0 are added, zero-extended. Bits 31:16 of that word have no effect on the sum.
- R3: Row r starts at word address r*MAX_W/2. Only the first ceil(width/2) words of each of the first height rows are read. Tail words and unused rows are never read and do not affect the sum.
- R4: The accumulator is 32 bits wide. It is cleared when a job is accepted and wraps modulo 2^32.
- R5: After the image, the engine reads exactly one word at word address MAX_W*MAX_H/2, which is byte offset MAX_W*MAX_H*2. match_o is 1 exactly when that word equals the computed sum.
- R6: A start with a width or height of 0, or above 64, pulses done_o on the next cycle with err_o=1, sum_o=0 and match_o=0, and issues no read.
- R7: done_o is a single-cycle pulse. For a valid job it arrives h*ceil(w/2)+3 clock edges after the edge that samples start_i. busy_o is high from the accepting edge until done_o rises.
- R8: A start_i asserted while busy_o is high is ignored. The running job finishes with its original dimensions and timing.
- R9: After reset, busy_o, done_o, err_o, match_o and rd_en_o are 0 and sum_o is 0.
- R10: sum_o, match_o and err_o keep their values after done_o until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a job; sampled while idle |
| width_i | input | DIM_W | Active width in pixels |
| height_i | input | DIM_W | Active height in rows |
| rd_en_o | output | 1 | Read request to buffer memory |
| rd_addr_o | output | ADDR_W | Word address of the read |
| rd_data_i | input | 32 | Read data, valid one cycle after rd_en_o |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last job had illegal dimensions |
| sum_o | output | 32 | Computed checksum |
| match_o | output | 1 | Sum equals stored signature word |

## Verification
For a legal job, results are due h*ceil(w/2)+3 edges after start is sampled. That count is one edge per image word, one for the signature fetch, one for the data that fetch returns, and one for the output register. For an illegal job they are due one edge after start is sampled. The bench drives start on a falling edge and keeps a free-running edge counter. It samples outputs only on falling edges and compares the edge on which done_o is first seen with the expected count. A read monitor checks every image address against the active window, and a hold check samples outputs several cycles after done.

// File: rtl/cks_pkg.sv
package cks_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_SIG  = 2'd2,
        ST_WAIT = 2'd3
    } cks_state_e;
endpackage

// File: rtl/cks_scan.sv
// Walks the active window word by word over a fixed-pitch buffer.
module cks_scan #(
    parameter int ROW_WORDS = 32,
    parameter int ADDR_W    = 12,
    parameter int DIM_W     = 7,
    parameter int COL_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [COL_W-1:0]  wlast_i,
    input  logic [DIM_W-1:0]  hlast_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              row_end_o,
    output logic              last_o
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [DIM_W-1:0] row;
        logic [COL_W-1:0] wlast;
        logic [DIM_W-1:0] hlast;
    } scan_t;

    scan_t s_d, s_q;

    assign addr_o    = ADDR_W'(s_q.row) * ADDR_W'(ROW_WORDS) + ADDR_W'(s_q.col);
    assign row_end_o = (s_q.col == s_q.wlast);
    assign last_o    = row_end_o && (s_q.row == s_q.hlast);

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.col   = '0;
            s_d.row   = '0;
            s_d.wlast = wlast_i;
            s_d.hlast = hlast_i;
        end else if (adv_i) begin
            if (row_end_o) begin
                s_d.col = '0;
                s_d.row = s_q.row + 1'b1;
            end else begin
                s_d.col = s_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cks_accum.sv
// 32-bit wrapping accumulator with optional low-half masking.
module cks_accum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        add_i,
    input  logic        half_i,
    input  logic [31:0] data_i,
    output logic [31:0] acc_o
);
    logic [31:0] acc_d, acc_q;
    logic [31:0] term;

    assign term  = half_i ? {16'h0000, data_i[15:0]} : data_i;
    assign acc_o = acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr_i)      acc_d = '0;
        else if (add_i) acc_d = acc_q + term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/cursor_cksum.sv
module cursor_cksum
    import cks_pkg::*;
#(
    parameter int MAX_W = 64,
    parameter int MAX_H = 64,
    localparam int DIM_W     = $clog2(((MAX_W > MAX_H) ? MAX_W : MAX_H) + 1),
    localparam int ROW_WORDS = MAX_W / 2,
    localparam int IMG_WORDS = ROW_WORDS * MAX_H,
    localparam int SIG_WORDS = 8,
    localparam int ADDR_W    = $clog2(IMG_WORDS + SIG_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIM_W-1:0]  width_i,
    input  logic [DIM_W-1:0]  height_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [31:0]       rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [31:0]       sum_o,
    output logic              match_o
);
    localparam int COL_W = $clog2(ROW_WORDS + 1);
    localparam logic [ADDR_W-1:0] SIG_ADDR = ADDR_W'(IMG_WORDS);

    typedef struct packed {
        cks_state_e  state;
        logic        odd;
        logic        pend;
        logic        half;
        logic        done;
        logic        err;
        logic        match;
        logic [31:0] sum;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              bad_dim;
    logic [DIM_W:0]    wwords;
    logic [COL_W-1:0]  wlast;
    logic [DIM_W-1:0]  hlast;
    logic              load, adv, clr;
    logic [ADDR_W-1:0] scan_addr;
    logic              row_end, last_word;
    logic [31:0]       acc;

    assign bad_dim = (width_i == '0) || (height_i == '0) ||
                     (int'(width_i) > MAX_W) || (int'(height_i) > MAX_H);
    assign wwords  = ({1'b0, width_i} + 1'b1) >> 1;
    assign wlast   = COL_W'(wwords - 1'b1);
    assign hlast   = height_i - 1'b1;

    cks_scan #(
        .ROW_WORDS(ROW_WORDS), .ADDR_W(ADDR_W), .DIM_W(DIM_W), .COL_W(COL_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .load_i(load), .wlast_i(wlast),
        .hlast_i(hlast), .adv_i(adv), .addr_o(scan_addr),
        .row_end_o(row_end), .last_o(last_word)
    );

    cks_accum u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .add_i(c_q.pend),
        .half_i(c_q.half), .data_i(rd_data_i), .acc_o(acc)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.pend  = 1'b0;
        c_d.half  = 1'b0;
        rd_en_o   = 1'b0;
        rd_addr_o = scan_addr;
        load      = 1'b0;
        adv       = 1'b0;
        clr       = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.sum   = '0;
                    c_d.match = 1'b0;
                    if (bad_dim) begin
                        c_d.done = 1'b1;
                        c_d.err  = 1'b1;
                    end else begin
                        c_d.err   = 1'b0;
                        c_d.odd   = width_i[0];
                        c_d.state = ST_READ;
                        load      = 1'b1;
                        clr       = 1'b1;
                    end
                end
            end
            ST_READ: begin
                rd_en_o  = 1'b1;
                adv      = 1'b1;
                c_d.pend = 1'b1;
                c_d.half = c_q.odd && row_end;
                if (last_word) c_d.state = ST_SIG;
            end
            ST_SIG: begin
                rd_en_o   = 1'b1;
                rd_addr_o = SIG_ADDR;
                c_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                c_d.done  = 1'b1;
                c_d.sum   = acc;
                c_d.match = (acc == rd_data_i);
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign busy_o  = (c_q.state != ST_IDLE);
    assign done_o  = c_q.done;
    assign err_o   = c_q.err;
    assign sum_o   = c_q.sum;
    assign match_o = c_q.match;
endmodule

// File: rtl/cursor_cksum_chk.sv
module cursor_cksum_chk #(
    parameter int MAX_W  = 64,
    parameter int MAX_H  = 64,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_en_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [31:0]       sum_o,
    input logic              match_o
);
    localparam int SIG = MAX_W * MAX_H / 2;

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r6_err_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (sum_o == 32'h0 && !match_o));

    a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (int'(rd_addr_o) <= SIG));

    a_r9_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_en_o);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(sum_o) && $stable(match_o) && $stable(err_o)));
endmodule

bind cursor_cksum cursor_cksum_chk #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_en_o(rd_en_o),
    .rd_addr_o(rd_addr_o), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .sum_o(sum_o), .match_o(match_o)
);

// File: tb/tb_cursor_cksum.sv
module tb_cursor_cksum;
    localparam int MAXW  = 64;
    localparam int MAXH  = 64;
    localparam int RW    = MAXW / 2;
    localparam int IMG   = RW * MAXH;
    localparam int WORDS = IMG + 8;
    localparam int DW    = 7;
    localparam int AW    = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] width_i = '0;
    logic [DW-1:0] height_i = '0;
    logic          rd_en_o;
    logic [AW-1:0] rd_addr_o;
    logic [31:0]   rd_data_i = '0;
    logic          busy_o, done_o, err_o, match_o;
    logic [31:0]   sum_o;

    logic [31:0] mem [0:WORDS-1];
    int compared = 0, mismatched = 0;
    int cyc = 0, reads = 0, bad_reads = 0;
    int cur_words = 0, cur_h = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cursor_cksum dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .width_i(width_i),
        .height_i(height_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .sum_o(sum_o), .match_o(match_o)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rd_en_o) begin
            rd_data_i <= mem[rd_addr_o];
            reads = reads + 1;
            if (int'(rd_addr_o) < IMG &&
                ((int'(rd_addr_o) % RW) >= cur_words || (int'(rd_addr_o) / RW) >= cur_h))
                bad_reads = bad_reads + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_sum(input int w, input int h);
        logic [31:0] s = 32'h0;
        for (int r = 0; r < h; r++) begin
            for (int p = 0; p + 1 < w; p += 2) s += mem[r*RW + p/2];
            if (w % 2 == 1) s += {16'h0, mem[r*RW + w/2][15:0]};
        end
        return s;
    endfunction

    task automatic fill(input logic [31:0] seed);
        for (int a = 0; a < WORDS; a++) mem[a] = (a * 32'h9E3779B1) ^ seed;
    endtask

    // Launch a job and wait for done; returns edges from launch to done.
    task automatic launch(input int w, input int h, output int lat);
        int t0, r0;
        cur_words = (w + 1) / 2;
        cur_h = h;
        @(negedge clk);
        width_i = DW'(w);
        height_i = DW'(h);
        start_i = 1'b1;
        t0 = cyc;
        r0 = reads;
        bad_reads = 0;
        @(negedge clk);
        start_i = 1'b0;
        lat = -1;
        for (int i = 0; i < 6000; i++) begin
            if (done_o) begin lat = cyc - t0; break; end
            @(negedge clk);
        end
        if (lat < 0) check(0, "watchdog", 0, 1);
        reads = reads - r0;
    endtask

    task automatic t_valid(input int w, input int h, input bool_sig_ok, input string tag);
        int lat;
        logic [31:0] exp = ref_sum(w, h);
        mem[IMG] = bool_sig_ok ? exp : exp + 32'h1;
        launch(w, h, lat);
        check(sum_o == exp, tag, sum_o, exp);
        check(lat == h * ((w + 1) / 2) + 3, "R7 latency", lat, h * ((w + 1) / 2) + 3);
        check(match_o == bool_sig_ok, "R5 match", match_o, bool_sig_ok);
        check(err_o == 1'b0, "R6 err low", err_o, 0);
        check(bad_reads == 0, "R3 tail not read", bad_reads, 0);
        check(reads == h * ((w + 1) / 2) + 1, "R5 one signature read", reads, h * ((w + 1) / 2) + 1);
    endtask

    task automatic t_reset();
        check(!busy_o && !done_o && !err_o && !match_o && !rd_en_o, "R9 reset flags",
              {busy_o, done_o, err_o, match_o, rd_en_o}, 0);
        check(sum_o == 32'h0, "R9 reset sum", sum_o, 0);
    endtask

    task automatic t_bad(input int w, input int h);
        int lat;
        launch(w, h, lat);
        check(lat == 1, "R6 bad dims latency", lat, 1);
        check(err_o && !match_o && sum_o == 32'h0, "R6 bad dims result",
              {err_o, match_o, sum_o}, 64'h1_0_00000000);
        check(reads == 0, "R6 no reads", reads, 0);
    endtask

    task automatic t_wrap();
        for (int a = 0; a < IMG; a++) mem[a] = 32'hFFFF_FFFF;
        t_valid(MAXW, MAXH, 1, "R4 wrap");
        check(sum_o == 32'hFFFF_F800, "R4 wrap value", sum_o, 32'hFFFF_F800);
    endtask

    task automatic t_busy_start();
        int t0, lat;
        logic [31:0] exp;
        fill(32'h1234_5678);
        exp = ref_sum(10, 4);
        mem[IMG] = exp;
        cur_words = 5; cur_h = 4;
        @(negedge clk);
        width_i = 7'd10; height_i = 7'd4; start_i = 1'b1; t0 = cyc;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        width_i = 7'd64; height_i = 7'd64; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        width_i = 7'd10; height_i = 7'd4;
        lat = -1;
        for (int i = 0; i < 200; i++) begin
            if (done_o) begin lat = cyc - t0; break; end
            @(negedge clk);
        end
        check(lat == 23, "R8 start while busy latency", lat, 23);
        check(sum_o == exp && match_o, "R8 start while busy sum", sum_o, exp);
        repeat (5) @(negedge clk);
        check(!busy_o, "R8 no second job", busy_o, 0);
        check(sum_o == exp && match_o && !err_o, "R10 hold", sum_o, exp);
    endtask

    task automatic t_odd_upper();
        // Upper halves of odd-tail words must not affect the sum.
        logic [31:0] s1;
        fill(32'hA5A5_0F0F);
        t_valid(5, 3, 1, "R2 odd width");
        s1 = sum_o;
        for (int r = 0; r < 3; r++) mem[r*RW + 2][31:16] = ~mem[r*RW + 2][31:16];
        t_valid(5, 3, 1, "R2 odd width flipped");
        check(sum_o == s1, "R2 upper half ignored", sum_o, s1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        fill(32'h0BAD_F00D);
        t_valid(2, 1, 1, "R1 single pair");
        t_valid(8, 6, 1, "R1 even width");
        t_valid(1, 4, 1, "R2 width one");
        t_valid(64, 2, 0, "R5 mismatch");
        fill(32'h5555_AAAA);
        t_valid(13, 64, 1, "R3 tall odd");
        t_valid(62, 5, 1, "R3 tail skip");
        t_odd_upper();
        t_wrap();
        t_bad(0, 5);
        t_bad(5, 0);
        t_bad(65, 5);
        t_bad(5, 100);
        fill(32'h7777_0001);
        t_valid(3, 3, 1, "R10 after error");
        repeat (4) @(negedge clk);
        check(sum_o == ref_sum(3, 3) && match_o, "R10 hold after done", sum_o, ref_sum(3, 3));
        t_busy_start();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule